// File: doc/BRIEF.md
# Power-Controller Command Mailbox

This block is the register window a host processor uses to hand commands to a power-management controller. The host fills two 32-bit request words and a wake-event mask, optionally preloads the two response words with extra arguments, and then writes the command word with its issue bit set. The mailbox captures the command code, marks the request pending, and presents the command and all four data words to a back-end port under a valid/ready handshake. Once the back end has taken it, the request is in progress until the back end pulses done. While it is in progress, the back end may write a 64-bit result into the response words and may also write into the request words.

If any enabled bit of the event mask is set when the command is issued, the request is held and not offered to the back end. It is released only when one of the selected event inputs, after a two-flop synchroniser, goes high. Mask bit 7 selects the standby-WFI event line. The host polls the status word to see when the request has completed, and then reads the results.

Top module: `pmc_mailbox`

## Requirements
- R1: After reset every register reads zero, the status word reads 0 (idle) and `beValid` is low.
- R2: The host bus is single-cycle and word-addressed. These offsets are read/write: 0x04 event mask (bits [7:0] kept, upper bits read zero), 0x0C request low, 0x10 request high, 0x14 response low and 0x18 response high. Writes to the status word at 0x08 are ignored. Offset 0x1C reads zero. Reads return zero when `busSel` is low or `busWr` is high.
- R3: A write to offset 0x00 with bit 8 set while status is idle latches bits [7:0] as the command code. The code reads back at offset 0x00 bits [7:0], with bit 8 reading zero. Status bits [1:0] become 2'b01 (pending) on the next cycle. Status never reads 2'b10.
- R4: While pending and not held by an event, `beValid` is high. `beCmd`, `beReqLo/Hi` and `beRspLo/Hi` always show the current register values.
- R5: In a cycle where `beValid` and `beReady` are both high, the request is accepted. Status becomes 2'b11 (in progress) on the next cycle, and `beValid` drops.
- R6: A `beDone` pulse while status is 2'b11 returns status to 2'b00 on the next cycle.
- R7: A command write with bit 8 set while status is not idle is ignored, and the command code is unchanged. A command write with bit 8 clear changes neither status nor the code.
- R8: If mask bits [7:0] are nonzero at issue, `beValid` stays low until a mask-selected event input is high. The event is seen through two synchroniser flops, so if the input is high at clock edge k, `beValid` rises after edge k+2. Unselected event bits have no effect.
- R9: While status is 2'b11, `beRspWe` loads `beRspData[31:0]` into response low and `beRspData[63:32]` into response high. `beReqWe` loads `beReqData` into the request words in the same way. Back-end writes in any other status are ignored.
- R10: When a host write and a back-end write target the same data word in the same cycle, the back-end value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Host access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address, word aligned |
| busWdata | input | 32 | Host write data |
| busRdata | output | 32 | Host read data (combinational) |
| evtIn | input | 8 | Asynchronous wake events; bit 7 is standby-WFI |
| beValid | output | 1 | Request offered to back end |
| beReady | input | 1 | Back end accepts the request |
| beCmd | output | 8 | Latched command code |
| beReqLo | output | 32 | Request word low |
| beReqHi | output | 32 | Request word high |
| beRspLo | output | 32 | Response word low (host-preloaded arguments) |
| beRspHi | output | 32 | Response word high |
| beDone | input | 1 | Completion pulse |
| beRspWe | input | 1 | Back-end response write enable |
| beRspData | input | 64 | Back-end response value |
| beReqWe | input | 1 | Back-end request-word write enable |
| beReqData | input | 64 | Back-end request-word value |

## Verification
Two functions can fall in the same clock. The first is a host write to a response or request word coinciding with a back-end write of that word while a request is in progress. The second is a fresh issue attempt arriving while a request is still pending or in progress. The bench drives both collisions deliberately: a host write to response low lands in the same cycle as `beRspWe`, and a command write with the issue bit lands while the first request is pending. A cycle-level behavioural model, updated on every edge from the requirements, predicts which value wins and that the command code stays put. Every output and every read is compared against the model on each clock.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int BUS_W     = 32;
  localparam int VALID_BIT = 8;

  // word indices inside the window; the host software relies on them
  localparam int IDX_CMD  = 0;
  localparam int IDX_MASK = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_RQLO = 3;
  localparam int IDX_RQHI = 4;
  localparam int IDX_RSLO = 5;
  localparam int IDX_RSHI = 6;
  localparam int NUM_DATA = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PEND = 2'b01,
    ST_BUSY = 2'b11
  } mboxState_e;

  typedef struct packed {
    logic latchCmd;
    logic beWrOpen;
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_sync.sv
`timescale 1ns/1ps
module mbox_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/mbox_datapath.sv
`timescale 1ns/1ps
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int EVT_W       = 8,
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BUS_W-1:0]    busWdata,
  output logic [BUS_W-1:0]    busRdata,
  input  logic [EVT_W-1:0]    evtIn,
  input  mboxStrobe_t         strobe,
  input  logic [1:0]          status,
  output logic                cmdWrite,
  output logic                maskNz,
  output logic                evtHit,
  output logic [CODE_W-1:0]   beCmd,
  output logic [BUS_W-1:0]    beReqLo,
  output logic [BUS_W-1:0]    beReqHi,
  output logic [BUS_W-1:0]    beRspLo,
  output logic [BUS_W-1:0]    beRspHi,
  input  logic                beRspWe,
  input  logic [2*BUS_W-1:0]  beRspData,
  input  logic                beReqWe,
  input  logic [2*BUS_W-1:0]  beReqData
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  wordIdx;
  logic              hostWr;
  logic              hostRd;
  logic [CODE_W-1:0] cmdQ;
  logic [EVT_W-1:0]  maskQ;
  logic [EVT_W-1:0]  evtSyncd;
  logic [BUS_W-1:0]  dataQ [NUM_DATA];
  int                rdIdx;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign hostWr  = busSel && busWr;
  assign hostRd  = busSel && !busWr;
  assign rdIdx   = int'(wordIdx);

  assign cmdWrite = hostWr && (wordIdx == IDX_W'(IDX_CMD)) && busWdata[VALID_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= '0;
      maskQ <= '0;
    end else begin
      if (strobe.latchCmd) cmdQ <= busWdata[CODE_W-1:0];
      if (hostWr && (wordIdx == IDX_W'(IDX_MASK))) maskQ <= busWdata[EVT_W-1:0];
    end
  end

  // request low/high then response low/high; the back end wins a same-cycle clash
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_DATA; k++) dataQ[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_DATA; k++) begin
        logic              beHit;
        logic [BUS_W-1:0]  beWord;
        beHit  = strobe.beWrOpen && ((k < 2) ? beReqWe : beRspWe);
        beWord = (k < 2) ? ((k % 2) == 0 ? beReqData[BUS_W-1:0] : beReqData[2*BUS_W-1:BUS_W])
                         : ((k % 2) == 0 ? beRspData[BUS_W-1:0] : beRspData[2*BUS_W-1:BUS_W]);
        if (beHit) dataQ[k] <= beWord;
        else if (hostWr && (wordIdx == IDX_W'(IDX_RQLO + k))) dataQ[k] <= busWdata;
      end
    end
  end

  mbox_sync #(.WIDTH(EVT_W), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (evtIn),
    .dout (evtSyncd)
  );

  assign evtHit = |(evtSyncd & maskQ);
  assign maskNz = |maskQ;

  assign beCmd   = cmdQ;
  assign beReqLo = dataQ[0];
  assign beReqHi = dataQ[1];
  assign beRspLo = dataQ[2];
  assign beRspHi = dataQ[3];

  always_comb begin
    busRdata = '0;
    if (hostRd) begin
      case (rdIdx)
        IDX_CMD:  busRdata[CODE_W-1:0] = cmdQ;
        IDX_MASK: busRdata[EVT_W-1:0]  = maskQ;
        IDX_STAT: busRdata[1:0]        = status;
        IDX_RQLO: busRdata = dataQ[0];
        IDX_RQHI: busRdata = dataQ[1];
        IDX_RSLO: busRdata = dataQ[2];
        IDX_RSHI: busRdata = dataQ[3];
        default:  busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_control.sv
`timescale 1ns/1ps
module mbox_control
  import mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrite,
  input  logic        maskNz,
  input  logic        evtHit,
  input  logic        beReady,
  input  logic        beDone,
  output mboxStrobe_t strobe,
  output logic [1:0]  status,
  output logic        beValid
);
  mboxState_e stateQ;
  logic       gatedQ;
  logic       issue;

  assign issue           = cmdWrite && (stateQ == ST_IDLE);
  assign strobe.latchCmd = issue;
  assign strobe.beWrOpen = (stateQ == ST_BUSY);
  assign beValid         = (stateQ == ST_PEND) && !gatedQ;
  assign status          = stateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      gatedQ <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: if (issue) begin
          stateQ <= ST_PEND;
          gatedQ <= maskNz;
        end
        ST_PEND: begin
          if (gatedQ) begin
            if (evtHit) gatedQ <= 1'b0;
          end else if (beReady) begin
            stateQ <= ST_BUSY;
          end
        end
        ST_BUSY: if (beDone) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pmc_mailbox.sv
`timescale 1ns/1ps
module pmc_mailbox
  import mbox_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int EVT_W       = 8,
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [EVT_W-1:0]   evtIn,
  output logic               beValid,
  input  logic               beReady,
  output logic [CODE_W-1:0]  beCmd,
  output logic [31:0]        beReqLo,
  output logic [31:0]        beReqHi,
  output logic [31:0]        beRspLo,
  output logic [31:0]        beRspHi,
  input  logic               beDone,
  input  logic               beRspWe,
  input  logic [63:0]        beRspData,
  input  logic               beReqWe,
  input  logic [63:0]        beReqData
);
  mboxStrobe_t strobe;
  logic [1:0]  status;
  logic        cmdWrite;
  logic        maskNz;
  logic        evtHit;

  mbox_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrite (cmdWrite),
    .maskNz   (maskNz),
    .evtHit   (evtHit),
    .beReady  (beReady),
    .beDone   (beDone),
    .strobe   (strobe),
    .status   (status),
    .beValid  (beValid)
  );

  mbox_datapath #(
    .ADDR_W(ADDR_W), .EVT_W(EVT_W), .CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .evtIn     (evtIn),
    .strobe    (strobe),
    .status    (status),
    .cmdWrite  (cmdWrite),
    .maskNz    (maskNz),
    .evtHit    (evtHit),
    .beCmd     (beCmd),
    .beReqLo   (beReqLo),
    .beReqHi   (beReqHi),
    .beRspLo   (beRspLo),
    .beRspHi   (beRspHi),
    .beRspWe   (beRspWe),
    .beRspData (beRspData),
    .beReqWe   (beReqWe),
    .beReqData (beReqData)
  );
endmodule

// File: rtl/mbox_checker.sv
`timescale 1ns/1ps
module mbox_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        status,
  input logic              beValid,
  input logic              beReady,
  input logic              beDone,
  input logic              issueTry,
  input logic [CODE_W-1:0] beCmd
);
  assert_legal_status_R3: assert property (@(posedge clk) disable iff (!rstN)
    status != 2'b10);

  assert_valid_pend_R4: assert property (@(posedge clk) disable iff (!rstN)
    beValid |-> status == 2'b01);

  assert_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (beValid && beReady) |=> (status == 2'b11 && !beValid));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'b11 && beDone) |=> status == 2'b00);

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issueTry && status != 2'b00) |=> $stable(beCmd));
endmodule

bind pmc_mailbox mbox_checker #(.CODE_W(CODE_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .status   (status),
  .beValid  (beValid),
  .beReady  (beReady),
  .beDone   (beDone),
  .issueTry (cmdWrite),
  .beCmd    (beCmd)
);

// File: tb/tb_pmc_mailbox.sv
`timescale 1ns/1ps
module tb_pmc_mailbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 0, busWr = 0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  evtIn = '0;
  logic        beValid, beReady = 0, beDone = 0, beRspWe = 0, beReqWe = 0;
  logic [7:0]  beCmd;
  logic [31:0] beReqLo, beReqHi, beRspLo, beRspHi;
  logic [63:0] beRspData = '0, beReqData = '0;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  pmc_mailbox dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn), .beValid(beValid),
    .beReady(beReady), .beCmd(beCmd), .beReqLo(beReqLo), .beReqHi(beReqHi),
    .beRspLo(beRspLo), .beRspHi(beRspHi), .beDone(beDone), .beRspWe(beRspWe),
    .beRspData(beRspData), .beReqWe(beReqWe), .beReqData(beReqData)
  );

  // behavioural reference model
  logic [1:0]  mSt = 0;
  logic [7:0]  mCmd = 0, mMask = 0, mS1 = 0, mS2 = 0;
  logic [31:0] mD [4] = '{default: '0};
  logic        mGated = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCmd = 0; mMask = 0; mS1 = 0; mS2 = 0; mGated = 0;
      foreach (mD[i]) mD[i] = 0;
    end else begin
      logic [1:0] nSt;
      logic       hw, open, hit;
      int         idx;
      nSt  = mSt;
      hw   = busSel && busWr;
      idx  = int'(busAddr[4:2]);
      open = (mSt == 2'b11);
      hit  = (mS2 & mMask) != 0;
      if (mSt == 2'b00) begin
        if (hw && idx == 0 && busWdata[8]) begin
          mCmd = busWdata[7:0]; mGated = (mMask != 0); nSt = 2'b01;
        end
      end else if (mSt == 2'b01) begin
        if (mGated) begin
          if (hit) mGated = 0;
        end else if (beReady) nSt = 2'b11;
      end else if (beDone) nSt = 2'b00;
      if (hw && idx == 1) mMask = busWdata[7:0];
      for (int k = 0; k < 4; k++) begin
        logic [63:0] src;
        logic        we;
        src = (k < 2) ? beReqData : beRspData;
        we  = open && ((k < 2) ? beReqWe : beRspWe);
        if (we) mD[k] = (k % 2 == 0) ? src[31:0] : src[63:32];
        else if (hw && idx == k + 3) mD[k] = busWdata;
      end
      mS2 = mS1; mS1 = evtIn; mSt = nSt;
    end
  end

  function automatic logic [31:0] modelRead();
    if (!(busSel && !busWr)) return 0;
    case (int'(busAddr[4:2]))
      0: return {24'b0, mCmd};
      1: return {24'b0, mMask};
      2: return {30'b0, mSt};
      3: return mD[0];
      4: return mD[1];
      5: return mD[2];
      6: return mD[3];
      default: return 0;
    endcase
  endfunction

  task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // compare every clock, just after inputs settle at the falling edge
  always @(negedge clk) begin
    #1;
    cmp("beValid", 64'(beValid), 64'((mSt == 2'b01) && !mGated));
    cmp("beCmd",   64'(beCmd), 64'(mCmd));
    cmp("beReqLo", 64'(beReqLo), 64'(mD[0]));
    cmp("beReqHi", 64'(beReqHi), 64'(mD[1]));
    cmp("beRspLo", 64'(beRspLo), 64'(mD[2]));
    cmp("beRspHi", 64'(beRspHi), 64'(mD[3]));
    cmp("busRdata", 64'(busRdata), 64'(modelRead()));
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busSel = 0; busWr = 0; beReady = 0; beDone = 0; beRspWe = 0; beReqWe = 0;
    end
  endtask

  task automatic hwr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    beReady = 0; beDone = 0; beRspWe = 0; beReqWe = 0;
  endtask

  task automatic hrd(logic [4:0] a);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    beReady = 0; beDone = 0; beRspWe = 0; beReqWe = 0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL %s watchdog: actual hung expected finished", curReq);
    finishRun();
  end

  initial begin
    idle(3);
    @(negedge clk); rstN = 1;
    curReq = "R1";
    for (int a = 0; a < 8; a++) hrd(5'(a * 4));

    curReq = "R2";
    hwr(5'h04, 32'hFFFF_FF80); hwr(5'h0C, 32'h1111_2222); hwr(5'h10, 32'h3333_4444);
    hwr(5'h14, 32'h5555_6666); hwr(5'h18, 32'h7777_8888); hwr(5'h08, 32'hFFFF_FFFF);
    hwr(5'h1C, 32'hDEAD_BEEF);
    for (int a = 0; a < 8; a++) hrd(5'(a * 4));
    hwr(5'h04, 32'h0);

    curReq = "R3";
    hwr(5'h00, 32'h0000_0022);   // bit 8 clear: nothing
    hrd(5'h08); hrd(5'h00);
    hwr(5'h00, 32'h0000_013C);
    hrd(5'h08); hrd(5'h00);

    curReq = "R7";
    hwr(5'h00, 32'h0000_0155); hwr(5'h00, 32'h0000_0044);
    hrd(5'h00); hrd(5'h08);

    curReq = "R5";
    @(negedge clk); busSel = 0; beReady = 1;
    hrd(5'h08);

    curReq = "R10";
    hwr(5'h14, 32'hAAAA_0000);
    beRspWe = 1; beRspData = 64'hCAFE_0001_BEEF_0002;
    curReq = "R9";
    @(negedge clk); busSel = 0; beRspWe = 0; beReqWe = 1; beReqData = 64'h0123_4567_89AB_CDEF;
    hwr(5'h00, 32'h0000_0166);   // issue while busy: ignored (R7)
    for (int a = 3; a < 7; a++) hrd(5'(a * 4));

    curReq = "R6";
    @(negedge clk); busSel = 0; beDone = 1;
    hrd(5'h08);
    curReq = "R9";
    @(negedge clk); busSel = 0; beRspWe = 1; beReqWe = 1;
    beRspData = 64'hFFFF_FFFF_FFFF_FFFF; beReqData = 64'h1;
    hrd(5'h14); hrd(5'h0C);

    curReq = "R8";
    hwr(5'h04, 32'h0000_0080);
    hwr(5'h00, 32'h0000_0177);
    idle(4);
    @(negedge clk); busSel = 0; evtIn = 8'h08;   // unselected event
    idle(5);
    @(negedge clk); evtIn = 8'h80;               // standby-WFI event
    @(negedge clk); evtIn = 8'h00;
    idle(4);
    hrd(5'h08);
    curReq = "R5";
    @(negedge clk); busSel = 0; beReady = 1;
    curReq = "R6";
    idle(2);
    @(negedge clk); beDone = 1;
    curReq = "R4";
    hwr(5'h04, 32'h0);
    hwr(5'h00, 32'h0000_0101);
    idle(3);
    @(negedge clk); beReady = 1;
    @(negedge clk); beReady = 0; beDone = 1;
    hrd(5'h08);
    idle(3);
    finishRun();
  end
endmodule